// File: doc/BRIEF.md
# Receive Character Match Wakeup

This block sits beside a serial receiver and inspects every received character. Each character, presented for one cycle by a valid strobe together with an 8-bit value, is compared against a bank of match entries. Each entry carries an enable bit, a per-bit don't-care mask and a reference value. An entry hits when every bit that the mask does not exclude equals the reference. Each entry has a sticky flag that records whether it has hit since the last clear. When any entry hits and the global wakeup enable is set, a latched wakeup request goes to the system control logic, which can then bring a sleeping processor back up.

Software reaches the match entries, the global enable and a write-one-to-clear status word through a simple single-cycle register port. A dedicated clear input resets the wakeup request and all hit flags at once.

Top module: `rx_char_wake`

## Requirements
- R1: After reset `wake_o` is 0, `hit_flags_o` is 0, and every register reads 0.
- R2: Register address i (0 to N_ENTRIES-1) holds match entry i: bit 0 is enable, bits [15:8] are the mask and bits [23:16] are the reference value. Address N_ENTRIES bit 0 is the global wakeup enable. Address N_ENTRIES+1 is the status word. Reads return the stored fields with all other bits 0, and an unmapped address reads 0.
- R3: A character hits an entry when ((char XOR reference) AND NOT mask) is zero. A mask bit of 1 is don't-care.
- R4: An entry whose enable bit is 0 never hits, even when its mask is 0xFF.
- R5: A hit sets that entry's flag even when the global enable is 0, but `wake_o` then stays low.
- R6: A hit while the global enable is 1 raises `wake_o` on the clock edge that samples the character. `wake_o` then stays high until it is cleared.
- R7: The status word holds `wake_o` in bit 0 and the hit flags in bits [8+N_ENTRIES-1:8], with entry i at bit 8+i. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: `clear_i` high for one cycle clears `wake_o` and all hit flags on that edge.
- R9: A hit in the same cycle as a clear (from `clear_i` or a status write) takes priority, so the hit's flag and wakeup are set after that edge.
- R10: The entries are evaluated in parallel and combined by OR. One character can set several flags at once.
- R11: While `rx_valid_i` is low, the value on `rx_char_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received character strobe |
| rx_char_i | input | 8 | Received character |
| clear_i | input | 1 | Clear wakeup and hit flags |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address, AW = clog2(N_ENTRIES+2) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| hit_flags_o | output | N_ENTRIES | Sticky per-entry hit flags |
| wake_o | output | 1 | Latched wakeup request |

## Verification
Nearly every internal fault shows up one edge after the character that exposes it. A comparator with a wrong mask polarity, or one that ignores an entry's enable bit, gives a wrong `hit_flags_o` bit and a wrong `wake_o` on the very next sample. A status register that fails to hold its value shows up on idle cycles after a wakeup, when `wake_o` drops without any clear. Faults in clear priority appear only when a hit and a clear share an edge, so the bench drives that case on purpose.

// File: rtl/rxm_pkg.sv
`timescale 1ns/1ps
package rxm_pkg;
  localparam int CHAR_W = 8;
  localparam int REG_W  = 32;
  localparam int MASK_LSB = 8;
  localparam int REF_LSB  = 16;
  localparam int FLAG_LSB = 8;

  typedef struct packed {
    logic              en;
    logic [CHAR_W-1:0] mask;
    logic [CHAR_W-1:0] ref_val;
  } match_ent_t;

  function automatic logic [REG_W-1:0] ent_to_word(match_ent_t e);
    logic [REG_W-1:0] w;
    w = '0;
    w[0] = e.en;
    w[MASK_LSB +: CHAR_W] = e.mask;
    w[REF_LSB  +: CHAR_W] = e.ref_val;
    return w;
  endfunction

  function automatic match_ent_t word_to_ent(logic [REG_W-1:0] w);
    match_ent_t e;
    e.en      = w[0];
    e.mask    = w[MASK_LSB +: CHAR_W];
    e.ref_val = w[REF_LSB  +: CHAR_W];
    return e;
  endfunction
endpackage

// File: rtl/rxm_regs.sv
`timescale 1ns/1ps
module rxm_regs
  import rxm_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int AW = 3
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [AW-1:0]                 addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output match_ent_t [N_ENTRIES-1:0]    ents_o,
  output logic                          wake_en_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_ENTRIES);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    localparam logic [AW-1:0] ENT_ADDR = AW'(i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         ents_o[i] <= '0;
      else if (wr_i && addr_i == ENT_ADDR) ents_o[i] <= word_to_ent(wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          wake_en_o <= 1'b0;
    else if (wr_i && addr_i == CTRL_ADDR) wake_en_o <= wdata_i[0];
  end
endmodule

// File: rtl/rxm_compare.sv
`timescale 1ns/1ps
module rxm_compare
  import rxm_pkg::*;
#(
  parameter int N_ENTRIES = 4
) (
  input  match_ent_t [N_ENTRIES-1:0] ents_i,
  input  logic                       valid_i,
  input  logic [CHAR_W-1:0]          char_i,
  output logic [N_ENTRIES-1:0]       hit_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    logic [CHAR_W-1:0] diff;
    always_comb begin
      // mask bit 1 = don't care
      diff     = (char_i ^ ents_i[i].ref_val) & ~ents_i[i].mask;
      hit_o[i] = valid_i && ents_i[i].en && (diff == '0);
    end
  end
endmodule

// File: rtl/rxm_status.sv
`timescale 1ns/1ps
module rxm_status #(
  parameter int N_ENTRIES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] hit_i,
  input  logic                 wake_en_i,
  input  logic                 clear_i,
  input  logic                 clr_wake_i,
  input  logic [N_ENTRIES-1:0] clr_flags_i,
  output logic [N_ENTRIES-1:0] flags_o,
  output logic                 wake_o
);
  logic [N_ENTRIES-1:0] flag_kill;
  logic                 wake_set;

  always_comb begin
    flag_kill = clear_i ? '1 : clr_flags_i;
    wake_set  = wake_en_i && (|hit_i);
  end

  // set beats clear so no hit is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      wake_o  <= 1'b0;
    end else begin
      flags_o <= (flags_o & ~flag_kill) | hit_i;
      if (wake_set)                    wake_o <= 1'b1;
      else if (clear_i || clr_wake_i)  wake_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_char_wake.sv
`timescale 1ns/1ps
module rx_char_wake
  import rxm_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  localparam int AW = $clog2(N_ENTRIES + 2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_char_i,
  input  logic                 clear_i,
  input  logic                 reg_wr_i,
  input  logic [AW-1:0]        reg_addr_i,
  input  logic [31:0]          reg_wdata_i,
  output logic [31:0]          reg_rdata_o,
  output logic [N_ENTRIES-1:0] hit_flags_o,
  output logic                 wake_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_ENTRIES);
  localparam logic [AW-1:0] STAT_ADDR = AW'(N_ENTRIES + 1);

  match_ent_t [N_ENTRIES-1:0] ents;
  logic                       wake_en;
  logic [N_ENTRIES-1:0]       hit_vec;
  logic                       stat_wr;
  logic                       clr_wake;
  logic [N_ENTRIES-1:0]       clr_flags;

  rxm_regs #(.N_ENTRIES(N_ENTRIES), .AW(AW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .ents_o    (ents),
    .wake_en_o (wake_en)
  );

  rxm_compare #(.N_ENTRIES(N_ENTRIES)) u_cmp (
    .ents_i  (ents),
    .valid_i (rx_valid_i),
    .char_i  (rx_char_i),
    .hit_o   (hit_vec)
  );

  always_comb begin
    stat_wr   = reg_wr_i && (reg_addr_i == STAT_ADDR);
    clr_wake  = stat_wr && reg_wdata_i[0];
    clr_flags = stat_wr ? reg_wdata_i[FLAG_LSB +: N_ENTRIES] : '0;
  end

  rxm_status #(.N_ENTRIES(N_ENTRIES)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit_vec),
    .wake_en_i   (wake_en),
    .clear_i     (clear_i),
    .clr_wake_i  (clr_wake),
    .clr_flags_i (clr_flags),
    .flags_o     (hit_flags_o),
    .wake_o      (wake_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (reg_addr_i == AW'(i)) reg_rdata_o = ent_to_word(ents[i]);
    end
    if (reg_addr_i == CTRL_ADDR) reg_rdata_o[0] = wake_en;
    if (reg_addr_i == STAT_ADDR) begin
      reg_rdata_o[0] = wake_o;
      reg_rdata_o[FLAG_LSB +: N_ENTRIES] = hit_flags_o;
    end
  end
endmodule

// File: rtl/rxm_checker.sv
`timescale 1ns/1ps
module rxm_checker #(
  parameter int N_ENTRIES = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_valid_i,
  input logic                 clear_i,
  input logic                 wake_o,
  input logic                 wake_en,
  input logic [N_ENTRIES-1:0] hit_vec,
  input logic [N_ENTRIES-1:0] hit_flags_o
);
  assert_hit_wakes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && (|hit_vec) && wake_en) |=> wake_o);

  assert_rise_needs_char_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(rx_valid_i));

  assert_clear_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !rx_valid_i) |=> (!wake_o && hit_flags_o == '0));

  assert_idle_no_set_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_i |=> ((hit_flags_o & ~$past(hit_flags_o)) == '0));

  assert_gate_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wake_en && !wake_o) |=> !wake_o);

  assert_all_hits_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_i |=> ((hit_flags_o & $past(hit_vec)) == $past(hit_vec)));
endmodule

bind rx_char_wake rxm_checker #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rx_valid_i  (rx_valid_i),
  .clear_i     (clear_i),
  .wake_o      (wake_o),
  .wake_en     (wake_en),
  .hit_vec     (hit_vec),
  .hit_flags_o (hit_flags_o)
);

// File: tb/sim_rx_char_wake.sv
`timescale 1ns/1ps
module sim_rx_char_wake;
  localparam int N  = 4;
  localparam int AW = $clog2(N + 2);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_char = '0;
  logic          clear = 1'b0;
  logic          reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  flags;
  logic          wake;

  always #4 clk = ~clk;

  rx_char_wake #(.N_ENTRIES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
    .clear_i(clear), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .hit_flags_o(flags), .wake_o(wake)
  );

  typedef struct {
    int           due;
    logic         wake;
    logic [N-1:0] flags;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;

  logic       m_en[N];
  logic [7:0] m_mask[N];
  logic [7:0] m_ref[N];
  logic       m_gen = 1'b0;
  logic       m_wake = 1'b0;
  logic [N-1:0] m_flags = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, model updated from the requirements
  task automatic step(input bit v, input logic [7:0] ch, input bit clr,
                      input bit wr, input int addr, input logic [31:0] wd, input string tag);
    logic [N-1:0] hits;
    logic [N-1:0] kill;
    exp_t e;
    @(negedge clk);
    rx_valid = v; rx_char = ch; clear = clr;
    reg_wr = wr; reg_addr = AW'(addr); reg_wdata = wd;
    for (int i = 0; i < N; i++)
      hits[i] = v && m_en[i] && (((ch ^ m_ref[i]) & ~m_mask[i]) == 8'h00);
    kill = clr ? '1 : ((wr && addr == N + 1) ? wd[8 +: N] : '0);
    m_flags = (m_flags & ~kill) | hits;
    if (m_gen && (|hits)) m_wake = 1'b1;
    else if (clr || (wr && addr == N + 1 && wd[0])) m_wake = 1'b0;
    if (wr && addr < N) begin
      m_en[addr] = wd[0]; m_mask[addr] = wd[15:8]; m_ref[addr] = wd[23:16];
    end
    if (wr && addr == N) m_gen = wd[0];
    e.due = cyc + 1; e.wake = m_wake; e.flags = m_flags; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    rx_valid = 1'b0; clear = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 8'h00, 1'b0, 1'b0, 0, 32'h0, tag);
  endtask

  task automatic rd_chk(input int addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = AW'(addr);
    #1;
    check(reg_rdata === exp, tag, reg_rdata, exp);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        exp_t e;
        e = exp_q.pop_front();
        check(wake === e.wake, {e.tag, " wake"}, {31'h0, wake}, {31'h0, e.wake});
        check(flags === e.flags, {e.tag, " flags"}, 32'(flags), 32'(e.flags));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_en[i] = 0; m_mask[i] = 0; m_ref[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    #1;
    check(wake === 1'b0, "R1 wake after reset", {31'h0, wake}, 0);
    check(flags === '0, "R1 flags after reset", 32'(flags), 0);
    for (int a = 0; a < N + 2; a++) rd_chk(a, 32'h0, "R1 register reset");
    // R2 layout
    step(0, 0, 0, 1, 0, 32'h00A5_0F01, "R2 write entry0");
    rd_chk(0, 32'h00A5_0F01, "R2 entry0 readback");
    step(0, 0, 0, 1, 3, 32'hFFFF_FFFF, "R2 write entry3");
    rd_chk(3, 32'h00FF_FF01, "R2 entry3 unused bits zero");
    step(0, 0, 0, 1, 3, 32'h0, "R2 zero entry3");
    rd_chk(6, 32'h0, "R2 unmapped addr 6");
    rd_chk(7, 32'h0, "R2 unmapped addr 7");
    // R5: gate off
    step(1, 8'hA3, 0, 0, 0, 0, "R5 hit with gate off");
    idle("R5 idle");
    rd_chk(N + 1, 32'h0000_0100, "R7 status layout");
    // R11
    step(0, 8'hA5, 0, 0, 0, 0, "R11 char without valid");
    // R7 W1C flags
    step(0, 0, 0, 1, N + 1, 32'h0000_0100, "R7 clear flag0");
    step(0, 0, 0, 1, N, 32'h1, "R6 set gate");
    rd_chk(N, 32'h1, "R2 gate readback");
    // R3 mismatch
    step(1, 8'hB5, 0, 0, 0, 0, "R3 upper nibble mismatch");
    step(1, 8'hAF, 0, 0, 0, 0, "R3 masked nibble match");
    idle("R6 hold 1");
    idle("R6 hold 2");
    step(0, 0, 0, 1, N + 1, 32'h0, "R7 write zero no effect");
    rd_chk(N + 1, 32'h0000_0101, "R7 status readback");
    step(0, 0, 0, 1, N + 1, 32'h0000_0101, "R7 clear wake and flag");
    // R4 disabled entry with full mask
    step(0, 0, 0, 1, 1, 32'h0000_FF00, "R4 entry1 disabled wildcard");
    step(1, 8'h00, 0, 0, 0, 0, "R4 no hit on disabled");
    step(1, 8'h5C, 0, 0, 0, 0, "R4 no hit on disabled 2");
    // R10 multiple hits
    step(0, 0, 0, 1, 2, 32'h0000_FF01, "R10 entry2 wildcard");
    step(1, 8'hA1, 0, 0, 0, 0, "R10 two entries hit");
    step(1, 8'h33, 0, 0, 0, 0, "R10 wildcard only");
    // R8
    step(0, 0, 1, 0, 0, 0, "R8 clear input");
    // R9 priority
    step(1, 8'hA1, 1, 0, 0, 0, "R9 hit beats clear_i");
    step(1, 8'h77, 0, 1, N + 1, 32'h0000_0F01, "R9 hit beats status write");
    idle("R9 settle");
    step(0, 0, 1, 0, 0, 0, "R8 final clear");
    idle("R8 settle");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule